// File: doc/BRIEF.md
# Sprite XOR Draw Engine

This block carries out one sprite-draw command on a monochrome framebuffer of 64 by 32 pixels that it holds itself. A request gives a column, a line, a row count N of up to 15 and a base address into byte memory. The engine reads N bytes through a synchronous read port, one byte per row. It shifts each byte into position across the addressed line and XORs it into the stored image. While it does this it tracks whether any lit pixel was turned dark. At the end it pulses done and presents that collision flag.

Both axes wrap. A sprite that runs past the right edge continues at column 0, and rows that run past the bottom line continue at line 0. Coordinates wider than the screen are reduced modulo the screen size. A second, independent combinational port returns any whole line of the image to a display scanner.

Top module: `spr_xor_draw`

## Requirements
- R1: After reset, busy_o, done_o, collide_o and mem_rd_o are 0, and every line read through the display port is all zeros.
- R2: An accepted command with N greater than 0 makes exactly N reads. Each read holds mem_rd_o high for one cycle, and the addresses are base, base+1, and so on, taken modulo 2^12. The byte is expected on mem_data_i in the cycle after the read.
- R3: Bit 7 of a sprite byte lands on column X and bit k lands on column X+7-k. On the display port, bit c of disp_row_o is the pixel in column c of line disp_y_i.
- R4: Sprite row r goes to line (Y + r) mod 32, and X and Y inputs of any value are taken modulo 64 and 32.
- R5: A set sprite bit toggles the pixel under it, and a clear sprite bit leaves its pixel unchanged. Drawing the same sprite twice restores the image.
- R6: Columns past 63 wrap to column 0 and onward.
- R7: Lines past 31 wrap to line 0 and onward.
- R8: collide_o is cleared when a command is accepted. When done_o is high, collide_o is 1 exactly when the command turned at least one lit pixel dark. It holds that value until the next command.
- R9: With N = 0, done_o rises in the cycle right after acceptance. No read is made, collide_o is 0 and the image is unchanged.
- R10: A start_i that arrives while busy_o is high has no effect. No read, write or extra done results from it.
- R11: done_o is high for exactly one cycle, 2N clock edges after the edge that accepted the command. busy_o is high from acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Command request, accepted when the engine is idle |
| x_i | input | 8 | Sprite column, taken modulo 64 |
| y_i | input | 8 | Sprite line, taken modulo 32 |
| n_i | input | 4 | Number of sprite rows |
| base_i | input | 12 | Byte address of the first sprite row |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| collide_o | output | 1 | Some lit pixel was cleared by the last command |
| mem_rd_o | output | 1 | Sprite memory read strobe |
| mem_addr_o | output | 12 | Sprite memory read address |
| mem_data_i | input | 8 | Sprite byte, valid the cycle after the read |
| disp_y_i | input | 5 | Line selected by the display scanner |
| disp_row_o | output | 64 | Pixels of the selected line, bit c is column c |

## Verification
The draw path is first driven with one asymmetric byte pair placed at the bottom-right corner. This separates a correct bit order from a mirrored one and separates a correct wrap on each axis from a clipped or offset one. A redraw of the same sprite separates XOR from OR or copy and raises the collision flag, and a zero-row command that follows shows the flag is cleared. A run of commands from a table, with out-of-range coordinates, full 15-row sprites and overlapping placements, is compared line by line with a model of the image. A read window that crosses the top of the address space, and a start request that arrives mid-command, check the address sequence and that busy requests are ignored.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } spr_state_e;

endpackage

// File: rtl/spr_row_merge.sv
// Places one sprite byte across a framebuffer line starting at column x_i,
// wrapping past the right edge. FB_W must be a power of two and at least 16.
module spr_row_merge #(
  parameter int FB_W = 64,
  parameter int X_W  = $clog2(FB_W)
) (
  input  logic [7:0]      byte_i,
  input  logic [X_W-1:0]  x_i,
  output logic [FB_W-1:0] mask_o
);

  for (genvar c = 0; c < FB_W; c++) begin : g_col
    localparam logic [X_W-1:0] COL = X_W'(c);
    logic [X_W-1:0] off;
    // distance of this column from the sprite origin, modulo the line width
    assign off       = COL - x_i;
    assign mask_o[c] = (off < X_W'(8)) ? byte_i[3'd7 - off[2:0]] : 1'b0;
  end

endmodule

// File: rtl/spr_fb_store.sv
// Framebuffer: FB_H lines of FB_W bits, one write port and two read ports.
module spr_fb_store #(
  parameter int FB_W = 64,
  parameter int FB_H = 32,
  parameter int Y_W  = $clog2(FB_H)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [Y_W-1:0]  wy_i,
  input  logic [FB_W-1:0] wdata_i,
  input  logic [Y_W-1:0]  ry_i,
  output logic [FB_W-1:0] rdata_o,
  input  logic [Y_W-1:0]  dy_i,
  output logic [FB_W-1:0] ddata_o
);

  logic [FB_W-1:0] line_q [FB_H];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < FB_H; r++) line_q[r] <= '0;
    end else begin
      for (int r = 0; r < FB_H; r++) begin
        if (we_i && (wy_i == Y_W'(r))) line_q[r] <= wdata_i;
      end
    end
  end

  assign rdata_o = line_q[ry_i];
  assign ddata_o = line_q[dy_i];

endmodule

// File: rtl/spr_draw_ctrl.sv
// Command sequencer: one read cycle and one write cycle per sprite row.
module spr_draw_ctrl
  import spr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int X_W    = 6,
  parameter int Y_W    = 5,
  parameter int N_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [X_W-1:0]    x_i,
  input  logic [Y_W-1:0]    y_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              hit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              collide_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              row_we_o,
  output logic [Y_W-1:0]    row_y_o,
  output logic [X_W-1:0]    x_o
);

  spr_state_e        state_q, state_d;
  logic [X_W-1:0]    x_q;
  logic [Y_W-1:0]    y_q;
  logic [N_W-1:0]    n_q;
  logic [ADDR_W-1:0] base_q;
  logic [N_W-1:0]    row_q, row_d;
  logic              coll_q, coll_d;
  logic              cfg_en, row_en, coll_en;
  logic              last_row;

  assign cfg_en   = start_i && (state_q == ST_IDLE);
  assign last_row = ((N_W+1)'(row_q) + (N_W+1)'(1)) == (N_W+1)'(n_q);

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    coll_d  = coll_q;
    row_en  = 1'b0;
    coll_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cfg_en) begin
          row_d   = '0;
          row_en  = 1'b1;
          coll_d  = 1'b0;
          coll_en = 1'b1;
          state_d = (n_i == '0) ? ST_DONE : ST_READ;
        end
      end
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: begin
        coll_d  = coll_q | hit_i;
        coll_en = 1'b1;
        if (last_row) begin
          state_d = ST_DONE;
        end else begin
          row_d   = row_q + N_W'(1);
          row_en  = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      n_q     <= '0;
      base_q  <= '0;
      row_q   <= '0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cfg_en) begin
        x_q    <= x_i;
        y_q    <= y_i;
        n_q    <= n_i;
        base_q <= base_i;
      end
      if (row_en)  row_q  <= row_d;
      if (coll_en) coll_q <= coll_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign mem_rd_o   = (state_q == ST_READ);
  assign row_we_o   = (state_q == ST_WRITE);
  assign collide_o  = coll_q;
  assign mem_addr_o = base_q + ADDR_W'(row_q);
  assign row_y_o    = y_q + Y_W'(row_q);
  assign x_o        = x_q;

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (!mem_rd_o && row_we_o));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && (row_q != '0)) |-> (mem_addr_o == $past(mem_addr_o, 2) + ADDR_W'(1)));

  assert_zero_rows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (n_i == '0)) |=> (done_o && !mem_rd_o && !collide_o));

  assert_coll_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> !collide_o);

endmodule

// File: rtl/spr_xor_draw.sv
// Sprite XOR draw engine with its own framebuffer.
module spr_xor_draw #(
  parameter int FB_W    = 64,
  parameter int FB_H    = 32,
  parameter int ADDR_W  = 12,
  parameter int COORD_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [COORD_W-1:0]       x_i,
  input  logic [COORD_W-1:0]       y_i,
  input  logic [3:0]               n_i,
  input  logic [ADDR_W-1:0]        base_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     collide_o,
  output logic                     mem_rd_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic [7:0]               mem_data_i,
  input  logic [$clog2(FB_H)-1:0]  disp_y_i,
  output logic [FB_W-1:0]          disp_row_o
);

  localparam int X_W = $clog2(FB_W);
  localparam int Y_W = $clog2(FB_H);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [X_W-1:0]  x_mod, x_cur;
  logic [Y_W-1:0]  y_mod, row_y;
  logic            row_we, hit;
  logic [FB_W-1:0] old_line, mask, new_line;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign x_mod = X_W'(x_i % COORD_W'(FB_W));
  assign y_mod = Y_W'(y_i % COORD_W'(FB_H));

  spr_draw_ctrl #(
    .ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W), .N_W(4)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .x_i       (x_mod),
    .y_i       (y_mod),
    .n_i       (n_i),
    .base_i    (base_i),
    .hit_i     (hit),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .collide_o (collide_o),
    .mem_rd_o  (mem_rd_o),
    .mem_addr_o(mem_addr_o),
    .row_we_o  (row_we),
    .row_y_o   (row_y),
    .x_o       (x_cur)
  );

  spr_row_merge #(.FB_W(FB_W), .X_W(X_W)) i_merge (
    .byte_i(mem_data_i),
    .x_i   (x_cur),
    .mask_o(mask)
  );

  assign new_line = old_line ^ mask;
  assign hit      = |(old_line & mask);

  spr_fb_store #(.FB_W(FB_W), .FB_H(FB_H), .Y_W(Y_W)) i_fb (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_i   (row_we),
    .wy_i   (row_y),
    .wdata_i(new_line),
    .ry_i   (row_y),
    .rdata_o(old_line),
    .dy_i   (disp_y_i),
    .ddata_o(disp_row_o)
  );

  assert_mask_bits_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    row_we |-> ($countones(mask) == $countones(mem_data_i)));

  assert_hit_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (row_we && hit) |=> collide_o);

endmodule

// File: tb/test_spr_xor_draw.sv
module test_spr_xor_draw;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {x[31:24], y[23:16], n[15:12], base[11:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0,   8'd0,  4'd5,  12'h000},
    {8'd10,  8'd3,  4'd3,  12'h010},
    {8'd60,  8'd4,  4'd4,  12'h020},
    {8'd20,  8'd30, 4'd6,  12'h030},
    {8'd10,  8'd3,  4'd3,  12'h010},
    {8'd130, 8'd40, 4'd15, 12'h100},
    {8'd63,  8'd31, 4'd8,  12'h200},
    {8'd5,   8'd0,  4'd1,  12'h000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  x_i, y_i;
  logic [3:0]  n_i;
  logic [11:0] base_i;
  logic        busy_o, done_o, collide_o, mem_rd_o;
  logic [11:0] mem_addr_o;
  logic [7:0]  mem_data_i;
  logic [4:0]  disp_y_i;
  logic [63:0] disp_row_o;

  logic [7:0]  mem [4096];
  logic [63:0] model [32];
  logic [11:0] rd_addr [64];
  int          rd_cnt;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spr_xor_draw i_spr_xor_draw (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .x_i(x_i), .y_i(y_i),
    .n_i(n_i), .base_i(base_i), .busy_o(busy_o), .done_o(done_o),
    .collide_o(collide_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .disp_y_i(disp_y_i), .disp_row_o(disp_row_o)
  );

  // synchronous sprite memory
  always @(posedge clk) if (mem_rd_o === 1'b1) mem_data_i <= mem[mem_addr_o];

  // read logger
  always @(negedge clk) begin
    if (mem_rd_o === 1'b1) begin
      if (rd_cnt < 64) rd_addr[rd_cnt] = mem_addr_o;
      rd_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_image(input string req);
    for (int r = 0; r < 32; r++) begin
      disp_y_i = 5'(r);
      #1;
      check(disp_row_o === model[r], req, disp_row_o, model[r]);
    end
  endtask

  task automatic run_draw(input logic [7:0] x, input logic [7:0] y, input logic [3:0] n,
                          input logic [11:0] base, input bit inject);
    logic       exp_coll;
    logic [7:0] bv;
    int         k, ln, col;
    exp_coll = 1'b0;
    for (int r = 0; r < int'(n); r++) begin
      bv = mem[12'(int'(base) + r)];
      ln = (int'(y) + r) % 32;
      for (int b = 0; b < 8; b++) begin
        if (bv[7-b]) begin
          col = (int'(x) + b) % 64;
          if (model[ln][col]) exp_coll = 1'b1;
          model[ln][col] = ~model[ln][col];
        end
      end
    end
    rd_cnt = 0;
    @(negedge clk);
    start_i = 1'b1; x_i = x; y_i = y; n_i = n; base_i = base;
    @(negedge clk);
    if (inject) begin
      x_i = 8'd1; y_i = 8'd1; n_i = 4'd2; base_i = 12'h300;
    end else begin
      start_i = 1'b0;
    end
    k = 0;
    while (!done_o && k < 200) begin
      @(negedge clk);
      start_i = 1'b0;
      k++;
    end
    check(k == 2 * int'(n), "R11 done latency", 64'(k), 64'(2 * int'(n)));
    check(collide_o === exp_coll, "R8 collision flag", 64'(collide_o), 64'(exp_coll));
    @(negedge clk);
    check(!done_o && !busy_o, "R11 single done pulse", {62'd0, done_o, busy_o}, 64'd0);
    @(negedge clk);
    check(!busy_o, "R10 no command launched afterwards", 64'(busy_o), 64'd0);
    check(rd_cnt == int'(n), "R2 read count", 64'(rd_cnt), 64'(n));
    for (int i = 0; i < rd_cnt && i < 64; i++)
      check(rd_addr[i] == 12'(int'(base) + i), "R2 read address",
            64'(rd_addr[i]), 64'(12'(int'(base) + i)));
    check_image("R3 R4 R5 image line");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 73 + 17) ^ (a >> 3));
    mem[12'h300] = 8'hC1;
    mem[12'h301] = 8'h18;
    for (int r = 0; r < 32; r++) model[r] = '0;
    rst_n = 1'b0; start_i = 1'b0; x_i = '0; y_i = '0; n_i = '0; base_i = '0;
    disp_y_i = '0; rd_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check({busy_o, done_o, collide_o, mem_rd_o} == 4'b0, "R1 idle outputs",
          {60'd0, busy_o, done_o, collide_o, mem_rd_o}, 64'd0);
    check_image("R1 cleared image");

    // R3 R6 R7: asymmetric bytes at the bottom-right corner
    run_draw(8'd62, 8'd31, 4'd2, 12'h300, 1'b0);
    disp_y_i = 5'd31; #1;
    check(disp_row_o === ((64'd1 << 63) | (64'd1 << 62) | (64'd1 << 5)),
          "R3 R6 line 31 bit order and wrap", disp_row_o,
          (64'd1 << 63) | (64'd1 << 62) | (64'd1 << 5));
    disp_y_i = 5'd0; #1;
    check(disp_row_o === ((64'd1 << 1) | (64'd1 << 2)), "R7 line 0 wrapped row",
          disp_row_o, (64'd1 << 1) | (64'd1 << 2));

    // R5 R8: redraw erases and collides
    run_draw(8'd62, 8'd31, 4'd2, 12'h300, 1'b0);
    check(collide_o === 1'b1, "R8 erase reports collision", 64'(collide_o), 64'd1);

    // R9: zero rows after a colliding command clears the flag
    run_draw(8'd7, 8'd7, 4'd0, 12'h123, 1'b0);
    check(collide_o === 1'b0, "R9 zero rows flag", 64'(collide_o), 64'd0);

    // R2: read window across the top of the address space
    run_draw(8'd33, 8'd12, 4'd2, 12'hFFF, 1'b0);

    // R10: a start during a command is ignored
    run_draw(8'd40, 8'd20, 4'd3, 12'h050, 1'b1);

    // table of commands, each compared with the image model (R4 R5 R6 R7 R8)
    for (int v = 0; v < NVEC; v++)
      run_draw(VEC[v][31:24], VEC[v][23:16], VEC[v][15:12], VEC[v][11:0], 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule